// File: doc/BRIEF.md
# Zero-Overhead Repeat and Loop Sequencer

This block is the part of a DSP program sequencer that runs hardware repeat and loop constructs without branch penalties. A repeat command makes the single instruction that follows it issue a programmed number of times. The block does this by holding instruction fetch so that the same instruction is presented again on each cycle. A loop command opens a context made of a pass count, a start address and an end address. Whenever the executing PC reaches the end address, the block supplies the start address as the next-PC override in that same cycle, so the jump back costs no extra cycle.

Loop contexts nest up to four deep, and each of the three loop fields keeps its own small stack. The four sequencer registers (repeat count, loop count, loop start, loop end) can also be reached through a general register-transfer port. This lets software save a loop context and restore it later. Writing the loop-end register pushes a whole context built from the staged count and start values. Reading the loop-end register pops the innermost context. Sticky flags record a push onto a full stack and a pop from an empty one.

Top module: `zol_seq`

## Requirements
- R1: When `rptCmd` is accepted with `pcValid` high and count N ≥ 1, the next issued instruction issues N times in total. `fetchHold` is high during its first N−1 issue cycles and low during the last one. N = 0 behaves like N = 1, with no hold.
- R2: The repeat count register is 21 bits wide and holds every value up to 1,048,576. It can be written and read back through the transfer port with select 0.
- R3: In a cycle where `pcValid` is high and `pcIn` equals the innermost loop end while the innermost count is above 1, `nextPcValid` is high and `nextPc` equals the loop start, all in that same cycle. The count then drops by one.
- R4: When the innermost loop end is reached with a count of 1 or less, there is no override and the innermost context is popped. The next outer loop, if one exists, then resumes its own end-address checks.
- R5: Four contexts can be held at once. A fifth push, whether from `loopCmd` or a loop-end write, sets `ovfFlag` and leaves every stacked context unchanged. `ovfFlag` stays set until reset.
- R6: A loop-end read while no context is held returns 0, sets `unfFlag` and changes nothing else. `unfFlag` stays set until reset.
- R7: The transfer select codes are 0 for repeat count, 1 for loop count, 2 for loop start and 3 for loop end. Writes with codes 1 and 2 go to staging registers. A write with code 3 pushes {staged count, staged start, written data}. Reads with codes 1 and 2 return the innermost context, or the staging register when no context is held. A read with code 3 returns the innermost end address and pops that context.
- R8: Reset empties the loop stacks, clears the loop-end entries and both flags, and ends any repeat in progress. It leaves the repeat count and the staged count and start values unchanged.
- R9: While `fetchHold` is high, no loop-end check takes place. If the repeated instruction sits at a loop end, the check happens on its final issue.
- R10: A cycle with `pcValid` low produces no override, pops nothing and decrements no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcValid | input | 1 | An instruction at `pcIn` executes this cycle |
| pcIn | input | 20 | Address of the executing instruction |
| rptCmd | input | 1 | Current instruction is a repeat command |
| rptCountIn | input | 21 | Repeat count operand |
| loopCmd | input | 1 | Current instruction opens a loop |
| loopCountIn | input | 16 | Loop pass count operand |
| loopStartIn | input | 20 | Loop start address operand |
| loopEndIn | input | 20 | Loop end address operand |
| xferWr | input | 1 | Register-transfer write strobe |
| xferRd | input | 1 | Register-transfer read strobe |
| xferSel | input | 2 | Register-transfer select (see R7) |
| xferWData | input | 24 | Register-transfer write data |
| xferRData | output | 24 | Register-transfer read data, zero-extended |
| nextPcValid | output | 1 | Take `nextPc` instead of the sequential address |
| nextPc | output | 20 | Loop start address used as the override |
| fetchHold | output | 1 | Re-issue the current instruction next cycle |
| ovfFlag | output | 1 | Sticky stack-overflow flag |
| unfFlag | output | 1 | Sticky stack-underflow flag |

## Verification
The assertions rely on several conditions holding at the inputs. At most one of `loopCmd`, a loop-end write and a loop-end read occurs in any cycle. The repeat operand never exceeds 2^20. A new repeat command is never issued while a repeat is still running. The stimulus holds to these rules: every vector row and every directed step drives at most one command or transfer. All transfer-port tests run with `pcValid` low, so the stacks change only through the action under test. Every repeat is allowed to finish before the next one is issued.

// File: rtl/zol_pkg.sv
`timescale 1ns/1ps
package zol_pkg;

  // Register-transfer select encoding (R7)
  typedef enum logic [1:0] {
    SEL_RC = 2'd0,
    SEL_LC = 2'd1,
    SEL_LS = 2'd2,
    SEL_LE = 2'd3
  } xferSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;        // write a context at the current depth
    logic pushFromCmd; // context comes from the loop operands, else staging + wdata
    logic pop;         // discard the innermost context
    logic decLc;       // decrement the innermost pass count
    logic stageLc;     // load the staged count
    logic stageLs;     // load the staged start
    logic rcLoadCmd;   // load the repeat counter from the operand
    logic rcLoadXfer;  // load the repeat counter from transfer data
    logic rcDec;       // count one repeated issue
  } dpCtl_t;

endpackage

// File: rtl/zol_dp.sv
`timescale 1ns/1ps
module zol_dp
  import zol_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  parameter int RPT_W  = 21,
  parameter int DATA_W = 24,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic [PTR_W-1:0]  depth,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [CNT_W-1:0]  loopCountIn,
  input  logic [ADDR_W-1:0] loopStartIn,
  input  logic [ADDR_W-1:0] loopEndIn,
  input  logic [RPT_W-1:0]  rptCountIn,
  input  xferSel_e          xferSel,
  input  logic [DATA_W-1:0] xferWData,
  output logic [DATA_W-1:0] xferRData,
  output logic [ADDR_W-1:0] nextPc,
  output logic              topLcGtOne,
  output logic              pcAtEnd,
  output logic              rcGtOne,
  output logic              rptOpNonZero
);

  logic [CNT_W-1:0]  lcArr [DEPTH];
  logic [ADDR_W-1:0] lsArr [DEPTH];
  logic [ADDR_W-1:0] leArr [DEPTH];

  logic [CNT_W-1:0]  stageLcQ;
  logic [ADDR_W-1:0] stageLsQ;
  logic [RPT_W-1:0]  rcQ;

  logic [CNT_W-1:0]  pushLc;
  logic [ADDR_W-1:0] pushLs;
  logic [ADDR_W-1:0] pushLe;

  logic [CNT_W-1:0]  topLc;
  logic [ADDR_W-1:0] topLs;
  logic [ADDR_W-1:0] topLe;
  logic              isEmpty;

  logic unusedWData;
  assign unusedWData = ^xferWData;

  assign isEmpty = (depth == '0);

  // Source of a pushed context
  always_comb begin
    if (ctl.pushFromCmd) begin
      pushLc = loopCountIn;
      pushLs = loopStartIn;
      pushLe = loopEndIn;
    end else begin
      pushLc = stageLcQ;
      pushLs = stageLsQ;
      pushLe = ADDR_W'(xferWData);
    end
  end

  // One stack slot per nesting level; each field has its own storage
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [CNT_W-1:0]  lcQ;
    logic [ADDR_W-1:0] lsQ;
    logic [ADDR_W-1:0] leQ;
    logic pushHere;
    logic topHere;

    assign pushHere = ctl.push  && (depth == PTR_W'(i));
    assign topHere  = ctl.decLc && (depth == PTR_W'(i + 1));

    // End addresses are cleared by reset (R8)
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        leQ <= '0;
      else if (pushHere) leQ <= pushLe;
    end

    // Counts and starts keep their contents across reset (R8)
    always_ff @(posedge clk) begin
      if (pushHere) begin
        lcQ <= pushLc;
        lsQ <= pushLs;
      end else if (topHere) begin
        lcQ <= lcQ - CNT_W'(1);
      end
    end

    assign lcArr[i] = lcQ;
    assign lsArr[i] = lsQ;
    assign leArr[i] = leQ;
  end

  // Innermost context view; zero when empty
  always_comb begin
    topLc = '0;
    topLs = '0;
    topLe = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (depth == PTR_W'(i + 1)) begin
        topLc = lcArr[i];
        topLs = lsArr[i];
        topLe = leArr[i];
      end
    end
  end

  // Staging registers and repeat counter: no reset (R8)
  always_ff @(posedge clk) begin
    if (ctl.stageLc) stageLcQ <= CNT_W'(xferWData);
    if (ctl.stageLs) stageLsQ <= ADDR_W'(xferWData);
    if (ctl.rcLoadCmd)       rcQ <= rptCountIn;
    else if (ctl.rcLoadXfer) rcQ <= RPT_W'(xferWData);
    else if (ctl.rcDec)      rcQ <= rcQ - RPT_W'(1);
  end

  // Transfer read mux (R7)
  always_comb begin
    unique case (xferSel)
      SEL_RC:  xferRData = DATA_W'(rcQ);
      SEL_LC:  xferRData = isEmpty ? DATA_W'(stageLcQ) : DATA_W'(topLc);
      SEL_LS:  xferRData = isEmpty ? DATA_W'(stageLsQ) : DATA_W'(topLs);
      default: xferRData = DATA_W'(topLe);
    endcase
  end

  assign nextPc       = topLs;
  assign topLcGtOne   = (topLc > CNT_W'(1));
  assign pcAtEnd      = (pcIn == topLe);
  assign rcGtOne      = (rcQ > RPT_W'(1));
  assign rptOpNonZero = (rptCountIn != '0);

  // R3: an override consumes exactly one pass of the innermost loop
  p_dec_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.decLc |=> (topLc == $past(topLc) - CNT_W'(1)));

  // R1: a counted repeat issue lowers the counter by one
  p_rc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.rcDec && !ctl.rcLoadCmd && !ctl.rcLoadXfer) |=> (rcQ == $past(rcQ) - RPT_W'(1)));

endmodule

// File: rtl/zol_ctrl.sv
`timescale 1ns/1ps
module zol_ctrl
  import zol_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pcValid,
  input  logic             rptCmd,
  input  logic             loopCmd,
  input  logic             xferWr,
  input  logic             xferRd,
  input  xferSel_e         xferSel,
  input  logic             topLcGtOne,
  input  logic             pcAtEnd,
  input  logic             rcGtOne,
  input  logic             rptOpNonZero,
  output dpCtl_t           ctl,
  output logic [PTR_W-1:0] depth,
  output logic             nextPcValid,
  output logic             fetchHold,
  output logic             ovfFlag,
  output logic             unfFlag
);

  logic rptActive;
  logic isEmpty, isFull;
  logic loopCmdEff, xferPushReq, xferPopReq, pushReq;
  logic pushOk, pushBad, popOk, popBad;
  logic loopEval, endPop;

  assign isEmpty = (depth == '0);
  assign isFull  = (depth == PTR_W'(DEPTH));

  assign loopCmdEff  = pcValid && loopCmd;
  assign xferPushReq = xferWr && (xferSel == SEL_LE);
  assign xferPopReq  = xferRd && (xferSel == SEL_LE);
  assign pushReq     = loopCmdEff || xferPushReq;

  assign pushOk  = pushReq && !isFull;
  assign pushBad = pushReq && isFull;
  assign popOk   = xferPopReq && !pushReq && !isEmpty;
  assign popBad  = xferPopReq && !pushReq && isEmpty;

  // Repeat: hold fetch until the last issue (R1)
  assign fetchHold = rptActive && rcGtOne;

  // Loop-end check: skipped while held (R9), stalled (R10) or on an explicit stack op
  assign loopEval    = pcValid && !fetchHold && !isEmpty && pcAtEnd
                       && !pushReq && !xferPopReq;
  assign nextPcValid = loopEval && topLcGtOne;
  assign endPop      = loopEval && !topLcGtOne;

  always_comb begin
    ctl             = '0;
    ctl.push        = pushOk;
    ctl.pushFromCmd = loopCmdEff;
    ctl.pop         = popOk || endPop;
    ctl.decLc       = nextPcValid;
    ctl.stageLc     = xferWr && (xferSel == SEL_LC);
    ctl.stageLs     = xferWr && (xferSel == SEL_LS);
    ctl.rcLoadCmd   = pcValid && rptCmd && rptOpNonZero;
    ctl.rcLoadXfer  = xferWr && (xferSel == SEL_RC);
    ctl.rcDec       = pcValid && rptActive;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth     <= '0;
      rptActive <= 1'b0;
      ovfFlag   <= 1'b0;
      unfFlag   <= 1'b0;
    end else begin
      if (ctl.push)     depth <= depth + PTR_W'(1);
      else if (ctl.pop) depth <= depth - PTR_W'(1);

      if (ctl.rcLoadCmd)                          rptActive <= 1'b1;
      else if (pcValid && rptActive && !rcGtOne)  rptActive <= 1'b0;

      if (pushBad) ovfFlag <= 1'b1;
      if (popBad)  unfFlag <= 1'b1;
    end
  end

  // R5: depth never exceeds the stack size
  p_depth_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= PTR_W'(DEPTH));

  // R5: a push onto a full stack flags and keeps depth
  p_full_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (loopCmdEff && isFull) |=> (ovfFlag && depth == PTR_W'(DEPTH)));

  // R5: overflow flag is sticky
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovfFlag |=> ovfFlag);

  // R6: underflow flag is sticky
  p_unf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unfFlag |=> unfFlag);

  // R3: jumping back never changes the nesting depth
  p_override_keeps_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nextPcValid |=> (depth == $past(depth)));

  // R9: no override while the repeated instruction is held
  p_hold_no_override_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetchHold |-> !nextPcValid);

  // R1: a held issue is always followed by a further issue of the repeat
  p_hold_continues_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pcValid && fetchHold && !rptCmd) |=> rptActive);

endmodule

// File: rtl/zol_seq.sv
`timescale 1ns/1ps
module zol_seq
  import zol_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  parameter int RPT_W  = 21,
  parameter int DATA_W = 24,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pcValid,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic              rptCmd,
  input  logic [RPT_W-1:0]  rptCountIn,
  input  logic              loopCmd,
  input  logic [CNT_W-1:0]  loopCountIn,
  input  logic [ADDR_W-1:0] loopStartIn,
  input  logic [ADDR_W-1:0] loopEndIn,
  input  logic              xferWr,
  input  logic              xferRd,
  input  logic [1:0]        xferSel,
  input  logic [DATA_W-1:0] xferWData,
  output logic [DATA_W-1:0] xferRData,
  output logic              nextPcValid,
  output logic [ADDR_W-1:0] nextPc,
  output logic              fetchHold,
  output logic              ovfFlag,
  output logic              unfFlag
);

  localparam int PTR_W = $clog2(DEPTH + 1);

  dpCtl_t           ctl;
  logic [PTR_W-1:0] depth;
  logic             topLcGtOne, pcAtEnd, rcGtOne, rptOpNonZero;
  xferSel_e         selE;

  assign selE = xferSel_e'(xferSel);

  zol_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pcValid(pcValid), .rptCmd(rptCmd),
    .loopCmd(loopCmd), .xferWr(xferWr), .xferRd(xferRd), .xferSel(selE),
    .topLcGtOne(topLcGtOne), .pcAtEnd(pcAtEnd), .rcGtOne(rcGtOne),
    .rptOpNonZero(rptOpNonZero), .ctl(ctl), .depth(depth),
    .nextPcValid(nextPcValid), .fetchHold(fetchHold),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  zol_dp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RPT_W(RPT_W),
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .depth(depth), .pcIn(pcIn),
    .loopCountIn(loopCountIn), .loopStartIn(loopStartIn),
    .loopEndIn(loopEndIn), .rptCountIn(rptCountIn), .xferSel(selE),
    .xferWData(xferWData), .xferRData(xferRData), .nextPc(nextPc),
    .topLcGtOne(topLcGtOne), .pcAtEnd(pcAtEnd), .rcGtOne(rcGtOne),
    .rptOpNonZero(rptOpNonZero)
  );

endmodule

// File: tb/tb_zol_seq.sv
`timescale 1ns/1ps
module tb_zol_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pcValid;
  logic [19:0] pcIn;
  logic        rptCmd;
  logic [20:0] rptCountIn;
  logic        loopCmd;
  logic [15:0] loopCountIn;
  logic [19:0] loopStartIn, loopEndIn;
  logic        xferWr, xferRd;
  logic [1:0]  xferSel;
  logic [23:0] xferWData;
  logic [23:0] xferRData;
  logic        nextPcValid;
  logic [19:0] nextPc;
  logic        fetchHold, ovfFlag, unfFlag;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  zol_seq dut (
    .clk(clk), .rst_n(rst_n), .pcValid(pcValid), .pcIn(pcIn),
    .rptCmd(rptCmd), .rptCountIn(rptCountIn), .loopCmd(loopCmd),
    .loopCountIn(loopCountIn), .loopStartIn(loopStartIn), .loopEndIn(loopEndIn),
    .xferWr(xferWr), .xferRd(xferRd), .xferSel(xferSel), .xferWData(xferWData),
    .xferRData(xferRData), .nextPcValid(nextPcValid), .nextPc(nextPc),
    .fetchHold(fetchHold), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  // kind: 0 none, 1 loop command, 2 repeat command
  typedef struct packed {
    logic [1:0]  kind;
    logic [19:0] pc;
    logic [20:0] cnt;
    logic [19:0] st;
    logic [19:0] en;
    logic        eNpv;
    logic [19:0] eNp;
    logic        eHold;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  // Rows tagged R3 (jump back), R4 (fall through / pop), R1 (repeat), R9 (repeat at loop end)
  localparam vec_t VEC [NV] = '{
    '{2'd1, 20'h100, 21'd2, 20'h101, 20'h102, 1'b0, 20'h0,   1'b0, 4'd3},
    '{2'd0, 20'h101, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd3},
    '{2'd0, 20'h102, 21'd0, 20'h0,   20'h0,   1'b1, 20'h101, 1'b0, 4'd3},
    '{2'd0, 20'h101, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd3},
    '{2'd0, 20'h102, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd4},
    '{2'd2, 20'h103, 21'd3, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd1},
    '{2'd0, 20'h104, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b1, 4'd1},
    '{2'd0, 20'h104, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b1, 4'd1},
    '{2'd0, 20'h104, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd1},
    '{2'd0, 20'h105, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd1},
    '{2'd1, 20'h200, 21'd2, 20'h201, 20'h204, 1'b0, 20'h0,   1'b0, 4'd3},
    '{2'd1, 20'h201, 21'd2, 20'h202, 20'h203, 1'b0, 20'h0,   1'b0, 4'd3},
    '{2'd0, 20'h202, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd3},
    '{2'd0, 20'h203, 21'd0, 20'h0,   20'h0,   1'b1, 20'h202, 1'b0, 4'd3},
    '{2'd0, 20'h202, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd3},
    '{2'd0, 20'h203, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd4},
    '{2'd0, 20'h204, 21'd0, 20'h0,   20'h0,   1'b1, 20'h201, 1'b0, 4'd4},
    '{2'd1, 20'h201, 21'd2, 20'h202, 20'h203, 1'b0, 20'h0,   1'b0, 4'd3},
    '{2'd0, 20'h202, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd3},
    '{2'd0, 20'h203, 21'd0, 20'h0,   20'h0,   1'b1, 20'h202, 1'b0, 4'd3},
    '{2'd0, 20'h202, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd3},
    '{2'd0, 20'h203, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd4},
    '{2'd0, 20'h204, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd4},
    '{2'd0, 20'h205, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd4},
    '{2'd1, 20'h300, 21'd2, 20'h301, 20'h302, 1'b0, 20'h0,   1'b0, 4'd3},
    '{2'd2, 20'h301, 21'd2, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd1},
    '{2'd0, 20'h302, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b1, 4'd9},
    '{2'd0, 20'h302, 21'd0, 20'h0,   20'h0,   1'b1, 20'h301, 1'b0, 4'd9},
    '{2'd0, 20'h301, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd9},
    '{2'd0, 20'h302, 21'd0, 20'h0,   20'h0,   1'b0, 20'h0,   1'b0, 4'd9}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    pcValid = 1'b0; pcIn = '0; rptCmd = 1'b0; rptCountIn = '0;
    loopCmd = 1'b0; loopCountIn = '0; loopStartIn = '0; loopEndIn = '0;
    xferWr = 1'b0; xferRd = 1'b0; xferSel = 2'd0; xferWData = '0;
  endtask

  // Move to the next negedge and clear inputs
  task automatic nextCyc();
    @(negedge clk);
    idle();
  endtask

  task automatic xwrite(input logic [1:0] sel, input logic [23:0] d);
    nextCyc();
    xferWr = 1'b1; xferSel = sel; xferWData = d;
  endtask

  // Read: value checked before the edge that may pop
  task automatic xread(input logic [1:0] sel, input logic [23:0] exp, input string req);
    nextCyc();
    xferRd = 1'b1; xferSel = sel;
    #2;
    chk(req, "xferRData", 32'(xferRData), 32'(exp));
  endtask

  task automatic execPc(input logic [19:0] pc, input logic valid);
    nextCyc();
    pcValid = valid; pcIn = pc;
    #2;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R8: reset state
    chk("R8", "nextPcValid", 32'(nextPcValid), 32'd0);
    chk("R8", "fetchHold",   32'(fetchHold),   32'd0);
    chk("R8", "ovfFlag",     32'(ovfFlag),     32'd0);
    chk("R8", "unfFlag",     32'(unfFlag),     32'd0);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      string rq;
      nextCyc();
      rq = $sformatf("R%0d row %0d", VEC[i].req, i);
      pcValid = 1'b1;
      pcIn    = VEC[i].pc;
      if (VEC[i].kind == 2'd1) begin
        loopCmd = 1'b1; loopCountIn = VEC[i].cnt[15:0];
        loopStartIn = VEC[i].st; loopEndIn = VEC[i].en;
      end else if (VEC[i].kind == 2'd2) begin
        rptCmd = 1'b1; rptCountIn = VEC[i].cnt;
      end
      #2;
      chk(rq, "nextPcValid", 32'(nextPcValid), 32'(VEC[i].eNpv));
      chk(rq, "fetchHold",   32'(fetchHold),   32'(VEC[i].eHold));
      if (VEC[i].eNpv) chk(rq, "nextPc", 32'(nextPc), 32'(VEC[i].eNp));
    end

    // R7: context pushed through the transfer port
    xwrite(2'd1, 24'd3);
    xwrite(2'd2, 24'h50);
    xwrite(2'd3, 24'h55);
    xread(2'd1, 24'd3,  "R7 read LC");
    xread(2'd2, 24'h50, "R7 read LS");
    execPc(20'h55, 1'b1);
    chk("R3 xfer ctx", "nextPcValid", 32'(nextPcValid), 32'd1);
    chk("R3 xfer ctx", "nextPc",      32'(nextPc),      32'h50);
    xread(2'd1, 24'd2, "R3 count after jump");
    xread(2'd3, 24'h55, "R7 read LE pops");
    xread(2'd1, 24'd3, "R7 staged LC when empty");
    execPc(20'h55, 1'b1);
    chk("R7 popped", "nextPcValid", 32'(nextPcValid), 32'd0);
    chk("R6 no flag yet", "unfFlag", 32'(unfFlag), 32'd0);

    // R10: stalled cycle at loop end does nothing
    nextCyc();
    pcValid = 1'b1; pcIn = 20'h60; loopCmd = 1'b1;
    loopCountIn = 16'd2; loopStartIn = 20'h5F; loopEndIn = 20'h61;
    execPc(20'h61, 1'b0);
    chk("R10 stall", "nextPcValid", 32'(nextPcValid), 32'd0);
    execPc(20'h61, 1'b1);
    chk("R10 count kept", "nextPcValid", 32'(nextPcValid), 32'd1);
    execPc(20'h61, 1'b1);
    chk("R10 then pop", "nextPcValid", 32'(nextPcValid), 32'd0);

    // R5: overflow on the fifth push, contents untouched
    xwrite(2'd1, 24'd1);
    xwrite(2'd2, 24'h10);
    for (int k = 0; k < 4; k++) xwrite(2'd3, 24'(24'h70 + k));
    nextCyc();
    #2;
    chk("R5 four held", "ovfFlag", 32'(ovfFlag), 32'd0);
    xwrite(2'd3, 24'h7F);
    nextCyc();
    #2;
    chk("R5 fifth push", "ovfFlag", 32'(ovfFlag), 32'd1);
    for (int k = 3; k >= 0; k--) xread(2'd3, 24'(24'h70 + k), "R5 stack intact");
    xread(2'd3, 24'd0, "R6 empty read");
    nextCyc();
    #2;
    chk("R6 underflow", "unfFlag", 32'(unfFlag), 32'd1);
    chk("R5 sticky",    "ovfFlag", 32'(ovfFlag), 32'd1);

    // R2: full-range repeat count
    xwrite(2'd0, 24'd1048576);
    xread(2'd0, 24'd1048576, "R2 readback");

    // R1: zero count means a single issue
    nextCyc();
    pcValid = 1'b1; pcIn = 20'h400; rptCmd = 1'b1; rptCountIn = 21'd0;
    execPc(20'h401, 1'b1);
    chk("R1 zero count", "fetchHold", 32'(fetchHold), 32'd0);

    // R8: reset keeps staged/repeat values, empties stack, clears flags
    xwrite(2'd1, 24'h15);
    xwrite(2'd2, 24'h33);
    xwrite(2'd0, 24'd9);
    xwrite(2'd3, 24'h44);
    nextCyc();
    rst_n = 1'b0;
    nextCyc();
    rst_n = 1'b1;
    #2;
    chk("R8 flags", "ovfFlag", 32'(ovfFlag), 32'd0);
    chk("R8 flags", "unfFlag", 32'(unfFlag), 32'd0);
    execPc(20'h44, 1'b1);
    chk("R8 stack emptied", "nextPcValid", 32'(nextPcValid), 32'd0);
    xread(2'd1, 24'h15, "R8 LC kept");
    xread(2'd2, 24'h33, "R8 LS kept");
    xread(2'd0, 24'd9,  "R8 RC kept");
    xread(2'd3, 24'd0,  "R8 LE cleared");

    nextCyc();
    finishRun();
  end

endmodule